// File: doc/BRIEF.md
# Configurable UART Frame Transmitter

This block turns queued characters into asynchronous serial frames on one transmit line. Software-side logic pushes characters into a small queue. A control engine pulls them one at a time and drives a start bit, five to eight data bits, an optional parity bit and one or two stop bits. A frame-format word sets the data width, the parity mode (none, even, odd, or a forced constant) and the stop count. The engine captures that format when each character starts, so the format must not change while a frame is on the line.

The bit clock comes from outside as a single-cycle tick at sixteen times the bit rate. A global enable and a transmit enable gate the start of new characters. A character already on the line always runs to its end. An optional clear-to-send gate holds back new characters while the far end is not ready. A break request forces the line low, but only after the current character has finished. The queue can act either as a FIFO of parameterised depth or as a single holding register. Empty, full and busy flags report its state.

Top module: `uart_tx_framer`

## Requirements
- R1: After reset, txEmpty is 1, busy and txFull are 0, and txLine is high.
- R2: A frame is one low start bit, then 5 + wordLen data bits (wordLen 2'b00..2'b11 giving 5..8) sent least-significant bit first, then the optional parity bit, then a high stop bit. The line is high between frames.
- R3: With parityEn=1 and stickPar=0, evenSel=1 makes the number of ones across the data and parity bits even, and evenSel=0 makes it odd.
- R4: With parityEn=1 and stickPar=1, the parity bit is fixed at 1 when evenSel=0 and at 0 when evenSel=1.
- R5: With twoStop=1, the line stays high for two full bit periods after the data or parity bits, even when another character is waiting.
- R6: While sendBreak=1, txLine is driven low once the character in progress has completed its stop bits. The character itself is sent intact. No new character starts until sendBreak returns to 0.
- R7: Clearing uartEn or txEn during a character lets that character finish. No further character starts until both enables are 1 again.
- R8: busy is 1 whenever the queue holds a character, even with uartEn=0. It stays 1 through the last stop bit and falls only once the line has finished that stop bit.
- R9: With ctsEnable=1, a queued character starts only while ctsActive=1. With ctsEnable=0, ctsActive is ignored.
- R10: With fifoEn=0, the queue holds one character. txFull is 1 while it is occupied, and a push while full is discarded.
- R11: With fifoEn=1, the queue holds DEPTH characters, which are sent in push order. txFull rises on the DEPTH-th entry, and pushes beyond that are discarded.
- R12: Every bit lasts exactly TICKS_PER_BIT (16) baudTick pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| baudTick | input | 1 | One-cycle pulse at 16x the bit rate |
| wrValid | input | 1 | Push wrData into the queue (dropped when full) |
| wrData | input | 8 | Character to queue |
| uartEn | input | 1 | Global enable for starting characters |
| txEn | input | 1 | Transmit enable for starting characters |
| fifoEn | input | 1 | 1: DEPTH-entry FIFO, 0: single holding register |
| wordLen | input | 2 | Data bits minus five |
| parityEn | input | 1 | Insert a parity bit |
| evenSel | input | 1 | Even parity (or stick value 0) when 1 |
| stickPar | input | 1 | Force parity bit to the complement of evenSel |
| twoStop | input | 1 | Send two stop bits |
| sendBreak | input | 1 | Hold line low after the current character |
| ctsEnable | input | 1 | Gate character start on ctsActive |
| ctsActive | input | 1 | Far end is ready to receive |
| txLine | output | 1 | Serial output, idles high |
| busy | output | 1 | Character queued or frame in progress |
| txEmpty | output | 1 | Queue empty |
| txFull | output | 1 | Queue full |

## Verification
A queue pointer or count that goes wrong shows up a whole frame later at the earliest: as a missing, repeated or reordered character on the line, or as a full or empty flag that disagrees with the number of accepted pushes. A wrong bit counter or tick counter corrupts the frame that is in flight. It shifts every later bit by a bit period, so a mid-bit sampler sees a wrong data, parity or stop value within that same frame. Stuck enable or break gating shows within one bit period, either as a line that falls when it should stay high or as a queued character that never leaves.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

  localparam int CHAR_W = 8;

  typedef enum logic [2:0] {
    SEL_MARK,
    SEL_START,
    SEL_DATA,
    SEL_PARITY,
    SEL_BREAK
  } txSel_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PARITY,
    ST_STOP
  } txState_e;

  typedef struct packed {
    logic   load;
    logic   shift;
    txSel_e sel;
  } txStrobe_t;

endpackage

// File: rtl/uart_tx_queue.sv
module uart_tx_queue #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fifoEn,
  input  logic              push,
  input  logic [DATA_W-1:0] pushData,
  input  logic              pop,
  output logic [DATA_W-1:0] popData,
  output logic              empty,
  output logic              full
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;
  localparam logic [CW-1:0] CAP = CW'(DEPTH);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wrPtr, rdPtr;
  logic [CW-1:0]     count;
  logic              doPush, doPop;

  assign empty   = (count == '0);
  assign full    = fifoEn ? (count == CAP) : !empty;
  assign doPush  = push && !full;
  assign doPop   = pop && !empty;
  assign popData = mem[rdPtr];

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= pushData;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) wrPtr <= wrPtr + AW'(1);
      if (doPop)  rdPtr <= rdPtr + AW'(1);
      case ({doPush, doPop})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
    end
  end

  // R11: occupancy never exceeds the configured depth
  p_no_overflow_r11: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CAP);

  // R10: a push into a full queue leaves the occupancy unchanged
  p_drop_full_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push && !pop) |=> $stable(count));

endmodule

// File: rtl/uart_tx_ctrl.sv
module uart_tx_ctrl
  import uart_tx_pkg::*;
#(
  parameter int TICKS_PER_BIT = 16
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      baudTick,
  input  logic      uartEn,
  input  logic      txEn,
  input  logic      ctsEnable,
  input  logic      ctsActive,
  input  logic      sendBreak,
  input  logic      qEmpty,
  input  logic [1:0] wordLen,
  input  logic      parityEn,
  input  logic      twoStop,
  output txStrobe_t strobe,
  output logic      frameActive
);
  localparam int TW = $clog2(TICKS_PER_BIT);
  localparam logic [TW-1:0] LAST_TICK = TW'(TICKS_PER_BIT - 1);

  txState_e    stateQ;
  logic [TW-1:0] tickCnt;
  logic [2:0]  bitCnt;
  logic        stopCnt;
  logic [1:0]  wordLenQ;
  logic        parEnQ, twoStopQ;
  logic        canStart, bitDone, lastData;

  assign canStart = (stateQ == ST_IDLE) && !qEmpty && uartEn && txEn
                    && (!ctsEnable || ctsActive) && !sendBreak;
  assign bitDone  = baudTick && (stateQ != ST_IDLE) && (tickCnt == LAST_TICK);
  assign lastData = (bitCnt == ({1'b0, wordLenQ} + 3'd4));
  assign frameActive = (stateQ != ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stateQ   <= ST_IDLE;
      tickCnt  <= '0;
      bitCnt   <= '0;
      stopCnt  <= 1'b0;
      wordLenQ <= 2'b00;
      parEnQ   <= 1'b0;
      twoStopQ <= 1'b0;
    end else if (canStart) begin
      stateQ   <= ST_START;
      tickCnt  <= '0;
      wordLenQ <= wordLen;
      parEnQ   <= parityEn;
      twoStopQ <= twoStop;
    end else if (stateQ != ST_IDLE && baudTick) begin
      tickCnt <= bitDone ? '0 : tickCnt + TW'(1);
      if (bitDone) begin
        case (stateQ)
          ST_START: begin
            stateQ <= ST_DATA;
            bitCnt <= '0;
          end
          ST_DATA: begin
            if (lastData) begin
              stopCnt <= 1'b0;
              stateQ  <= parEnQ ? ST_PARITY : ST_STOP;
            end else begin
              bitCnt <= bitCnt + 3'd1;
            end
          end
          ST_PARITY: begin
            stateQ  <= ST_STOP;
            stopCnt <= 1'b0;
          end
          ST_STOP: begin
            if (twoStopQ && !stopCnt) stopCnt <= 1'b1;
            else                      stateQ  <= ST_IDLE;
          end
          default: stateQ <= ST_IDLE;
        endcase
      end
    end
  end

  always_comb begin
    strobe.load  = canStart;
    strobe.shift = (stateQ == ST_DATA) && bitDone && !lastData;
    case (stateQ)
      ST_START:  strobe.sel = SEL_START;
      ST_DATA:   strobe.sel = SEL_DATA;
      ST_PARITY: strobe.sel = SEL_PARITY;
      ST_STOP:   strobe.sel = SEL_MARK;
      default:   strobe.sel = sendBreak ? SEL_BREAK : SEL_MARK;
    endcase
  end

  // R9: with flow control on and the far end not ready, no character starts
  p_cts_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (stateQ == ST_IDLE && ctsEnable && !ctsActive) |=> (stateQ == ST_IDLE));

  // R5: the first of two stop bits is followed by a second
  p_two_stop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (stateQ == ST_STOP && bitDone && twoStopQ && !stopCnt) |=> (stateQ == ST_STOP));

  // R7: dropping an enable mid-character never cuts the frame short
  p_graceful_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (stateQ == ST_DATA && !(uartEn && txEn)) |=> (stateQ != ST_IDLE));

  // R12: bit timing advances only on baud ticks
  p_tick_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (stateQ != ST_IDLE && !baudTick) |=> $stable(tickCnt));

endmodule

// File: rtl/uart_tx_datapath.sv
module uart_tx_datapath
  import uart_tx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  txStrobe_t         strobe,
  input  logic [CHAR_W-1:0] loadData,
  input  logic [1:0]        wordLen,
  input  logic              evenSel,
  input  logic              stickPar,
  output logic              txLine
);
  logic [CHAR_W-1:0] shiftQ;
  logic              parQ;
  logic [CHAR_W-1:0] lenMask;
  logic              dataXor, parNext;

  assign lenMask = 8'hFF >> (2'd3 - wordLen);
  assign dataXor = ^(loadData & lenMask);
  assign parNext = stickPar ? !evenSel : (evenSel ? dataXor : !dataXor);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shiftQ <= '0;
      parQ   <= 1'b0;
    end else if (strobe.load) begin
      shiftQ <= loadData;
      parQ   <= parNext;
    end else if (strobe.shift) begin
      shiftQ <= {1'b0, shiftQ[CHAR_W-1:1]};
    end
  end

  always_comb begin
    case (strobe.sel)
      SEL_START:  txLine = 1'b0;
      SEL_DATA:   txLine = shiftQ[0];
      SEL_PARITY: txLine = parQ;
      SEL_BREAK:  txLine = 1'b0;
      default:    txLine = 1'b1;
    endcase
  end

endmodule

// File: rtl/uart_tx_framer.sv
module uart_tx_framer
  import uart_tx_pkg::*;
#(
  parameter int DEPTH         = 8,
  parameter int TICKS_PER_BIT = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       baudTick,
  input  logic       wrValid,
  input  logic [7:0] wrData,
  input  logic       uartEn,
  input  logic       txEn,
  input  logic       fifoEn,
  input  logic [1:0] wordLen,
  input  logic       parityEn,
  input  logic       evenSel,
  input  logic       stickPar,
  input  logic       twoStop,
  input  logic       sendBreak,
  input  logic       ctsEnable,
  input  logic       ctsActive,
  output logic       txLine,
  output logic       busy,
  output logic       txEmpty,
  output logic       txFull
);
  txStrobe_t         strobe;
  logic              frameActive;
  logic              qEmpty, qFull;
  logic [CHAR_W-1:0] headData;

  uart_tx_queue #(.DATA_W(CHAR_W), .DEPTH(DEPTH)) uQueue (
    .clk(clk), .rst_n(rst_n), .fifoEn(fifoEn),
    .push(wrValid), .pushData(wrData), .pop(strobe.load),
    .popData(headData), .empty(qEmpty), .full(qFull)
  );

  uart_tx_ctrl #(.TICKS_PER_BIT(TICKS_PER_BIT)) uCtrl (
    .clk(clk), .rst_n(rst_n), .baudTick(baudTick),
    .uartEn(uartEn), .txEn(txEn), .ctsEnable(ctsEnable), .ctsActive(ctsActive),
    .sendBreak(sendBreak), .qEmpty(qEmpty), .wordLen(wordLen),
    .parityEn(parityEn), .twoStop(twoStop),
    .strobe(strobe), .frameActive(frameActive)
  );

  uart_tx_datapath uPath (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .loadData(headData),
    .wordLen(wordLen), .evenSel(evenSel), .stickPar(stickPar),
    .txLine(txLine)
  );

  assign busy    = !qEmpty || frameActive;
  assign txEmpty = qEmpty;
  assign txFull  = qFull;

  // R6: outside a frame the line is only low under a break request
  p_break_level_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!txLine && !frameActive) |-> sendBreak);

  // R8: busy falls only after the line has been high for the stop bit
  p_busy_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(txLine));

  // R10: the queue is never reported empty and full at once
  p_flags_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(txEmpty && txFull));

endmodule

// File: tb/sim_uart_tx_framer.sv
module sim_uart_tx_framer;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic baudTick = 1'b0;
  logic wrValid = 1'b0;
  logic [7:0] wrData = 8'h00;
  logic uartEn = 1'b1, txEn = 1'b1, fifoEn = 1'b1;
  logic [1:0] wordLen = 2'b11;
  logic parityEn = 1'b0, evenSel = 1'b0, stickPar = 1'b0, twoStop = 1'b0;
  logic sendBreak = 1'b0, ctsEnable = 1'b0, ctsActive = 1'b0;
  logic txLine, busy, txEmpty, txFull;

  int nChecks = 0;
  int nFail = 0;
  bit finished = 0;
  bit monOn = 1;
  logic [7:0] expQ[$];

  uart_tx_framer #(.DEPTH(8), .TICKS_PER_BIT(16)) u0 (
    .clk(clk), .rst_n(rst_n), .baudTick(baudTick), .wrValid(wrValid), .wrData(wrData),
    .uartEn(uartEn), .txEn(txEn), .fifoEn(fifoEn), .wordLen(wordLen),
    .parityEn(parityEn), .evenSel(evenSel), .stickPar(stickPar), .twoStop(twoStop),
    .sendBreak(sendBreak), .ctsEnable(ctsEnable), .ctsActive(ctsActive),
    .txLine(txLine), .busy(busy), .txEmpty(txEmpty), .txFull(txFull)
  );

  always #4 clk = ~clk;

  initial forever begin
    @(negedge clk);
    baudTick = ~baudTick;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] lenMask(input logic [1:0] wl);
    return 8'hFF >> (3 - wl);
  endfunction

  function automatic logic expParity(input logic [7:0] d, input logic [1:0] wl,
                                     input logic ev, input logic st);
    logic x;
    x = ^(d & lenMask(wl));
    if (st) return !ev;
    return ev ? x : !x;
  endfunction

  task automatic decodeFrame();
    logic [7:0] got;
    logic [7:0] exp;
    logic pbit;
    int nb;
    got = 8'h00;
    pbit = 1'b0;
    nb = 5 + int'(wordLen);
    repeat (15) @(negedge clk);
    chk(txLine == 1'b0, "R2 start bit low", txLine, 0);
    for (int i = 0; i < nb; i++) begin
      repeat (32) @(negedge clk);
      got[i] = txLine;
    end
    if (parityEn) begin
      repeat (32) @(negedge clk);
      pbit = txLine;
    end
    for (int s = 0; s < (twoStop ? 2 : 1); s++) begin
      repeat (32) @(negedge clk);
      chk(txLine == 1'b1, (s == 1) ? "R5 second stop high" : "R2 stop high", txLine, 1);
      chk(busy == 1'b1, "R8 busy through stop", busy, 1);
    end
    if (expQ.size() == 0) begin
      chk(1'b0, "R2 unexpected frame", got, -1);
    end else begin
      exp = expQ.pop_front();
      chk(got == (exp & lenMask(wordLen)), "R2 data LSB first", got, exp & lenMask(wordLen));
      if (parityEn)
        chk(pbit == expParity(exp, wordLen, evenSel, stickPar),
            stickPar ? "R4 stick parity" : "R3 parity", pbit,
            expParity(exp, wordLen, evenSel, stickPar));
    end
  endtask

  initial begin
    logic prevLine;
    prevLine = 1'b1;
    forever begin
      @(negedge clk);
      if (monOn && rst_n && prevLine && !txLine) begin
        decodeFrame();
      end
      prevLine = txLine;
    end
  end

  task automatic pushByte(input logic [7:0] b, input bit track);
    @(negedge clk);
    wrValid = 1'b1;
    wrData = b;
    if (track) expQ.push_back(b);
    @(negedge clk);
    wrValid = 1'b0;
  endtask

  task automatic waitIdle();
    for (int i = 0; i < 20000 && busy; i++) @(negedge clk);
    chk(!busy, "R8 busy clears after last stop", busy, 0);
  endtask

  task automatic waitFall();
    for (int i = 0; i < 2000 && txLine; i++) @(negedge clk);
  endtask

  task automatic sendOne(input logic [1:0] wl, input logic pe, input logic ev,
                         input logic st, input logic ts, input logic [7:0] b);
    wordLen = wl; parityEn = pe; evenSel = ev; stickPar = st; twoStop = ts;
    pushByte(b, 1);
    waitIdle();
    chk(expQ.size() == 0, "R2 frame delivered", expQ.size(), 0);
  endtask

  initial begin
    int cnt;
    repeat (5) @(negedge clk);
    // R1 reset state
    chk(txEmpty == 1'b1, "R1 txEmpty after reset", txEmpty, 1);
    chk(busy == 1'b0, "R1 busy after reset", busy, 0);
    chk(txFull == 1'b0, "R1 txFull after reset", txFull, 0);
    chk(txLine == 1'b1, "R1 line idle high", txLine, 1);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R12 start bit of a character whose bit0 is 1 lasts 16 ticks (32 clocks)
    wordLen = 2'b11; parityEn = 0; twoStop = 0;
    pushByte(8'h01, 1);
    waitFall();
    cnt = 0;
    while (!txLine && cnt < 1000) begin
      @(negedge clk);
      cnt++;
    end
    chk(cnt >= 31 && cnt <= 33, "R12 bit lasts 16 ticks", cnt, 32);
    waitIdle();

    // R3 / R4 / R5 directed parity and stop cases
    sendOne(2'b11, 1, 1, 0, 0, 8'h03);
    sendOne(2'b11, 1, 0, 0, 0, 8'h03);
    sendOne(2'b10, 1, 0, 1, 0, 8'h00);
    sendOne(2'b11, 1, 1, 1, 0, 8'hFF);
    sendOne(2'b00, 1, 1, 0, 1, 8'hFF);
    wordLen = 2'b01; parityEn = 0; twoStop = 1;
    pushByte(8'h2A, 1);
    pushByte(8'h15, 1);
    waitIdle();
    chk(expQ.size() == 0, "R5 back-to-back two stops", expQ.size(), 0);

    // R2 R3 R4 R5 constrained random
    void'($urandom(32'h1357));
    for (int r = 0; r < 30; r++) begin
      int n;
      wordLen  = 2'($urandom_range(0, 3));
      parityEn = 1'($urandom_range(0, 1));
      evenSel  = 1'($urandom_range(0, 1));
      stickPar = 1'($urandom_range(0, 1));
      twoStop  = 1'($urandom_range(0, 1));
      n = $urandom_range(1, 4);
      for (int k = 0; k < n; k++) pushByte(8'($urandom_range(0, 255)), 1);
      waitIdle();
      chk(expQ.size() == 0, "R2 random frames delivered", expQ.size(), 0);
    end
    wordLen = 2'b11; parityEn = 0; stickPar = 0; twoStop = 0;

    // R8 busy while disabled
    uartEn = 0;
    pushByte(8'h5A, 1);
    chk(busy == 1'b1, "R8 busy on queued while disabled", busy, 1);
    chk(txEmpty == 1'b0, "R8 txEmpty clears", txEmpty, 0);
    repeat (200) @(negedge clk);
    chk(txLine == 1'b1 && expQ.size() == 1, "R8 nothing sent while disabled", txLine, 1);
    uartEn = 1;
    waitIdle();
    chk(txEmpty == 1'b1 && expQ.size() == 0, "R8 sent after enable", expQ.size(), 0);

    // R7 graceful stop, via uartEn then via txEn
    for (int v = 0; v < 2; v++) begin
      pushByte(8'hA5, 1);
      pushByte(8'h3C, 1);
      waitFall();
      repeat (100) @(negedge clk);
      if (v == 0) uartEn = 0; else txEn = 0;
      for (int i = 0; i < 2000 && expQ.size() > 1; i++) @(negedge clk);
      repeat (800) @(negedge clk);
      chk(expQ.size() == 1, "R7 current char completes, next held", expQ.size(), 1);
      chk(txLine == 1'b1, "R7 line idle after stop", txLine, 1);
      chk(busy == 1'b1 && txEmpty == 1'b0, "R7 held char still queued", busy, 1);
      uartEn = 1; txEn = 1;
      waitIdle();
      chk(expQ.size() == 0, "R7 resumes after re-enable", expQ.size(), 0);
    end

    // R6 break waits for the current character
    pushByte(8'hC3, 1);
    waitFall();
    repeat (64) @(negedge clk);
    sendBreak = 1;
    for (int i = 0; i < 2000 && expQ.size() > 0; i++) @(negedge clk);
    chk(expQ.size() == 0, "R6 character finished under break", expQ.size(), 0);
    monOn = 0;
    waitIdle();
    repeat (100) @(negedge clk);
    chk(txLine == 1'b0, "R6 line low during break", txLine, 0);
    sendBreak = 0;
    repeat (2) @(negedge clk);
    chk(txLine == 1'b1, "R6 line high after break release", txLine, 1);
    monOn = 1;
    repeat (4) @(negedge clk);

    // R9 clear-to-send gating
    ctsEnable = 1; ctsActive = 0;
    pushByte(8'h81, 1);
    repeat (600) @(negedge clk);
    chk(expQ.size() == 1 && txLine == 1'b1, "R9 held without CTS", expQ.size(), 1);
    ctsActive = 1;
    waitIdle();
    chk(expQ.size() == 0, "R9 sent once CTS asserted", expQ.size(), 0);
    ctsEnable = 0; ctsActive = 0;
    pushByte(8'h42, 1);
    waitIdle();
    chk(expQ.size() == 0, "R9 CTS ignored when gating off", expQ.size(), 0);

    // R10 single holding register
    uartEn = 0; fifoEn = 0;
    pushByte(8'h99, 1);
    chk(txFull == 1'b1, "R10 full with one entry", txFull, 1);
    chk(txEmpty == 1'b0, "R10 not empty with one entry", txEmpty, 0);
    pushByte(8'h66, 0);
    chk(txFull == 1'b1, "R10 still full after dropped push", txFull, 1);
    uartEn = 1;
    waitIdle();
    repeat (400) @(negedge clk);
    chk(expQ.size() == 0 && txEmpty == 1'b1, "R10 only held char sent", expQ.size(), 0);

    // R11 FIFO depth
    uartEn = 0; fifoEn = 1;
    for (int i = 0; i < 8; i++) begin
      pushByte(8'(i * 17 + 1), 1);
      if (i == 6) chk(txFull == 1'b0, "R11 not full at DEPTH-1", txFull, 0);
    end
    chk(txFull == 1'b1, "R11 full at DEPTH", txFull, 1);
    pushByte(8'hEE, 0);
    pushByte(8'hDD, 0);
    uartEn = 1;
    waitIdle();
    repeat (400) @(negedge clk);
    chk(expQ.size() == 0, "R11 DEPTH chars sent in order, extras dropped", expQ.size(), 0);

    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      nChecks++;
      nFail++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
      $finish;
    end
  end

endmodule